// File: doc/BRIEF.md
# Floating-point single store unit

This unit handles the four single-precision floating-point store instructions of a 32-bit fixed-width instruction set. It decodes an incoming instruction word and names the registers it wants to read. It then takes the base and index values from a 64-bit general-register read port. The value to store comes already narrowed to single precision from a separate converter. From these the unit forms a 32-bit effective address and issues one 4-byte store request, held under a valid/ready handshake until memory accepts it.

The unit has two addressing modes: a register base plus a sign-extended 16-bit displacement, and a register base plus a second register. Each mode exists with and without base update. The update variants write the effective address back into the base register once the store has been accepted. An update variant whose base field is zero is an illegal encoding and is reported. A store issued while the floating-point unit is disabled raises an unavailable fault instead of touching memory. Each completed store is followed by a one-cycle strobe telling the fetch logic to advance the program counter by 4.

The unit handles one instruction at a time. It accepts a new word only while idle.

Top module: `fpStoreUnit`

## Requirements
- R1: Instruction bits are numbered 31 (most significant) down to 0. The primary opcode is instWord[31:26] and the extended opcode is instWord[10:1]. decodeValid is high exactly for primary opcode 52, primary opcode 53, and primary opcode 31 with extended opcode 663 or 695. Any other word is consumed with no store request, no register writeback, no fault and no program-counter strobe.
- R2: In the displacement forms (52 no update, 53 update), the source FP register is instWord[25:21], the base field is instWord[20:16] and the displacement is instWord[15:0]. The effective address is the low 32 bits of the 64-bit base plus the sign-extended displacement.
- R3: In the indexed forms (31/663 no update, 31/695 update), the index register field is instWord[15:11]. The effective address is the low 32 bits of the base plus the index register value.
- R4: In the two non-update forms, a base field of 0 uses a literal zero as base, whatever register 0 holds.
- R5: An update form with base field 0 pulses invalidForm for one cycle, in the cycle after acceptance. It issues no store, no writeback and no program-counter strobe.
- R6: A store raises memReqValid in the cycle after acceptance. memReqValid holds, with memAddr and memData unchanged, until a cycle in which memReqReady is high. memData[31:24] is the byte for address memAddr and memData[7:0] the byte for memAddr+3, so memData equals the single-precision source value.
- R7: For update forms, in the cycle after the handshake, gprWrEn is high with gprWrIdx equal to the base field and gprWrData equal to the zero-extended effective address. Non-update forms never raise gprWrEn.
- R8: pcAdvance pulses for exactly one cycle, in the cycle after each store handshake, and at no other time.
- R9: If fpEnable is low when a recognised store is accepted, fpUnavail pulses for one cycle in the next cycle and no store is issued. An illegal update encoding (R5) takes precedence over this fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Unit idle, word taken when instValid is also high |
| instWord | input | 32 | Instruction word |
| fpEnable | input | 1 | Floating-point unit enabled |
| decodeValid | output | 1 | instWord is one of the four stores |
| raIdx | output | 5 | Base register read index |
| rbIdx | output | 5 | Index register read index |
| fsIdx | output | 5 | FP source register index for the converter |
| raData | input | 64 | Base register value |
| rbData | input | 64 | Index register value |
| fsData | input | 32 | Source value already narrowed to single precision |
| memReqValid | output | 1 | Store request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Effective address |
| memData | output | 32 | Store data, byte at memAddr in bits 31:24 |
| gprWrEn | output | 1 | Base register writeback strobe |
| gprWrIdx | output | 5 | Writeback register index |
| gprWrData | output | 64 | Writeback value |
| pcAdvance | output | 1 | Advance program counter by 4 |
| invalidForm | output | 1 | Illegal update encoding |
| fpUnavail | output | 1 | Floating-point unavailable fault |

## Verification
The timing after a word is accepted at edge k is as follows. decodeValid is combinational and is due in the cycle the word is offered. The store request or a fault pulse is visible after edge k. Writeback and pcAdvance appear one cycle after whichever edge completes the handshake. The memory-ready line is stalled in a repeating pattern, so the handshake edge moves from one store to the next. For that reason the monitor does not count cycles from issue. It samples at the falling edge and anchors each check to the event itself: a request seen with ready high is popped and compared, and the next falling edge must show the writeback and program-counter strobe. Any event arriving while the expected queue is empty is reported, which is how the unrecognised words are shown to have no effect.

// File: rtl/fpStorePkg.sv
package fpStorePkg;
  localparam int INST_W = 32;
  localparam int XLEN = 64;
  localparam int ADDR_W = 32;
  localparam int REG_W = 5;
  localparam int OP_W = 6;
  localparam int XO_W = 10;
  localparam logic [OP_W-1:0] OP_IMM = 6'd52;
  localparam logic [OP_W-1:0] OP_IMMU = 6'd53;
  localparam logic [OP_W-1:0] OP_EXT = 6'd31;
  localparam logic [XO_W-1:0] XO_IDX = 10'd663;
  localparam logic [XO_W-1:0] XO_IDXU = 10'd695;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE, S_FAULT} ctlState_t;

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;
endpackage

// File: rtl/fpStoreDatapath.sv
module fpStoreDatapath
  import fpStorePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [INST_W-1:0] instWord,
  input  logic [XLEN-1:0]   raData,
  input  logic [XLEN-1:0]   rbData,
  input  logic [31:0]       fsData,
  output logic              decodeValid,
  output logic              isUpdate,
  output logic              raZero,
  output logic [REG_W-1:0]  raIdx,
  output logic [REG_W-1:0]  rbIdx,
  output logic [REG_W-1:0]  fsIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic [REG_W-1:0]  gprWrIdx,
  output logic [XLEN-1:0]   gprWrData
);
  logic [OP_W-1:0] opcode;
  logic [XO_W-1:0] xo;
  logic isImm, isImmU, isIdx, isIdxU, isIndexed;
  logic [XLEN-1:0] baseVal, offsetVal, sum;
  logic [ADDR_W-1:0] eaNext;

  assign opcode = instWord[31:26];
  assign xo = instWord[10:1];
  assign fsIdx = instWord[25:21];
  assign raIdx = instWord[20:16];
  assign rbIdx = instWord[15:11];

  assign isImm = (opcode == OP_IMM);
  assign isImmU = (opcode == OP_IMMU);
  assign isIdx = (opcode == OP_EXT) && (xo == XO_IDX);
  assign isIdxU = (opcode == OP_EXT) && (xo == XO_IDXU);
  assign isIndexed = isIdx || isIdxU;
  assign isUpdate = isImmU || isIdxU;
  assign decodeValid = isImm || isImmU || isIdx || isIdxU;
  assign raZero = (raIdx == '0);

  always_comb begin
    baseVal = (raZero && !isUpdate) ? '0 : raData;
    offsetVal = isIndexed ? rbData
                          : {{(XLEN-16){instWord[15]}}, instWord[15:0]};
    sum = baseVal + offsetVal;
    eaNext = sum[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
      gprWrIdx <= '0;
    end else if (strobe.capture) begin
      memAddr <= eaNext;
      memData <= fsData;
      gprWrIdx <= raIdx;
    end
  end

  assign gprWrData = {{(XLEN-ADDR_W){1'b0}}, memAddr};
endmodule

// File: rtl/fpStoreControl.sv
module fpStoreControl
  import fpStorePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic       decodeValid,
  input  logic       isUpdate,
  input  logic       raZero,
  input  logic       fpEnable,
  input  logic       memReqReady,
  output ctlStrobe_t strobe,
  output logic       instReady,
  output logic       memReqValid,
  output logic       gprWrEn,
  output logic       pcAdvance,
  output logic       invalidForm,
  output logic       fpUnavail
);
  ctlState_t state;
  logic updReg, faultIsForm, accept;

  assign instReady = (state == S_IDLE);
  assign accept = instReady && instValid && decodeValid;
  assign strobe.capture = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      updReg <= 1'b0;
      faultIsForm <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          updReg <= isUpdate;
          if (isUpdate && raZero) begin
            faultIsForm <= 1'b1;
            state <= S_FAULT;
          end else if (!fpEnable) begin
            faultIsForm <= 1'b0;
            state <= S_FAULT;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: if (memReqReady) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign memReqValid = (state == S_REQ);
  assign pcAdvance = (state == S_DONE);
  assign gprWrEn = (state == S_DONE) && updReg;
  assign invalidForm = (state == S_FAULT) && faultIsForm;
  assign fpUnavail = (state == S_FAULT) && !faultIsForm;

  assert_wb_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |-> $past(memReqValid && memReqReady));
  assert_pc_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |=> !pcAdvance);
  assert_unknown_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (instReady && instValid && !decodeValid) |=> (instReady && !memReqValid && !fpUnavail && !invalidForm));
  assert_bad_form_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isUpdate && raZero) |=> (invalidForm && !fpUnavail && !memReqValid));
  assert_fp_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !fpEnable && !(isUpdate && raZero)) |=> (fpUnavail && !memReqValid));
endmodule

// File: rtl/fpStoreUnit.sv
module fpStoreUnit
  import fpStorePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [INST_W-1:0] instWord,
  input  logic              fpEnable,
  output logic              decodeValid,
  output logic [REG_W-1:0]  raIdx,
  output logic [REG_W-1:0]  rbIdx,
  output logic [REG_W-1:0]  fsIdx,
  input  logic [XLEN-1:0]   raData,
  input  logic [XLEN-1:0]   rbData,
  input  logic [31:0]       fsData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              gprWrEn,
  output logic [REG_W-1:0]  gprWrIdx,
  output logic [XLEN-1:0]   gprWrData,
  output logic              pcAdvance,
  output logic              invalidForm,
  output logic              fpUnavail
);
  ctlStrobe_t strobe;
  logic isUpdate, raZero;

  fpStoreDatapath dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instWord(instWord),
    .raData(raData), .rbData(rbData), .fsData(fsData),
    .decodeValid(decodeValid), .isUpdate(isUpdate), .raZero(raZero),
    .raIdx(raIdx), .rbIdx(rbIdx), .fsIdx(fsIdx),
    .memAddr(memAddr), .memData(memData),
    .gprWrIdx(gprWrIdx), .gprWrData(gprWrData)
  );

  fpStoreControl ctl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .decodeValid(decodeValid),
    .isUpdate(isUpdate), .raZero(raZero), .fpEnable(fpEnable),
    .memReqReady(memReqReady), .strobe(strobe), .instReady(instReady),
    .memReqValid(memReqValid), .gprWrEn(gprWrEn), .pcAdvance(pcAdvance),
    .invalidForm(invalidForm), .fpUnavail(fpUnavail)
  );

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memAddr) && $stable(memData)));
endmodule

// File: tb/fpStoreUnit_test.sv
module fpStoreUnit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic instReady;
  logic [31:0] instWord = '0;
  logic fpEnable = 1'b1;
  logic decodeValid;
  logic [4:0] raIdx, rbIdx, fsIdx, gprWrIdx;
  logic [63:0] raData, rbData, gprWrData;
  logic [31:0] fsData, memAddr, memData;
  logic memReqValid, memReqReady, gprWrEn, pcAdvance, invalidForm, fpUnavail;

  always #5 clk = ~clk;

  fpStoreUnit uut (.*);

  typedef struct {
    int kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic wb;
    logic [4:0] wbIdx;
    logic [63:0] wbData;
    string req;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  logic [63:0] gpr[32];
  logic [63:0] refGpr[32];
  logic [31:0] fpr[32];
  int tests = 0;
  int fails = 0;
  int unexpected = 0;
  logic [3:0] readyCnt = '0;
  logic pendDone = 1'b0;
  logic prevStall = 1'b0;
  logic [31:0] prevAddr, prevData;

  assign raData = gpr[raIdx];
  assign rbData = gpr[rbIdx];
  assign fsData = fpr[fsIdx];
  assign memReqReady = (readyCnt[1:0] != 2'd0);

  always @(posedge clk) begin
    readyCnt <= readyCnt + 4'd1;
    if (gprWrEn) gpr[gprWrIdx] <= gprWrData;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares events to scoreboard at falling edges
  always @(negedge clk) if (rstN) begin
    if (prevStall) begin
      check("R6 hold", {memReqValid, memAddr == prevAddr, memData == prevData}, 3'b111);
    end
    prevStall = memReqValid && !memReqReady;
    prevAddr = memAddr;
    prevData = memData;
    if (pendDone) begin
      check("R8 pcAdvance", pcAdvance, 1);
      check("R7 wbEn", gprWrEn, cur.wb);
      if (cur.wb) check("R7 wb", {gprWrIdx, gprWrData}, {cur.wbIdx, cur.wbData});
      pendDone = 1'b0;
    end else if (pcAdvance || gprWrEn) begin
      unexpected++;
      $display("FAIL R8 stray strobe actual=%b expected=0", {pcAdvance, gprWrEn});
    end
    if ((memReqValid && memReqReady) || fpUnavail || invalidForm) begin
      if (expQ.size() == 0) begin
        unexpected++;
        $display("FAIL R1 unexpected event actual=%b expected=000",
                 {memReqValid, fpUnavail, invalidForm});
      end else begin
        cur = expQ.pop_front();
        if (cur.kind == 0) begin
          check({cur.req, " req"}, {memReqValid, fpUnavail, invalidForm}, 3'b100);
          check({cur.req, " addr"}, memAddr, cur.addr);
          check("R6 data", memData, cur.data);
          pendDone = memReqValid && memReqReady;
        end else if (cur.kind == 1) begin
          check({cur.req, " invalidForm"}, {memReqValid, fpUnavail, invalidForm}, 3'b001);
        end else begin
          check({cur.req, " fpUnavail"}, {memReqValid, fpUnavail, invalidForm}, 3'b010);
        end
      end
    end
  end

  function automatic logic [31:0] encImm(bit upd, int fs, int ra, logic [15:0] d);
    return {upd ? 6'd53 : 6'd52, 5'(fs), 5'(ra), d};
  endfunction
  function automatic logic [31:0] encIdx(bit upd, int fs, int ra, int rb);
    return {6'd31, 5'(fs), 5'(ra), 5'(rb), upd ? 10'd695 : 10'd663, 1'b0};
  endfunction

  // driver: offers one word, pushes expectation, waits for idle
  task automatic issue(logic [31:0] w, bit fpOn, string req);
    logic [5:0] op = w[31:26];
    logic [9:0] xo = w[10:1];
    bit known, upd, idx;
    int ra = int'(w[20:16]);
    int rb = int'(w[15:11]);
    int fs = int'(w[25:21]);
    logic [63:0] base, sum;
    exp_t e;
    idx = (op == 6'd31);
    upd = (op == 6'd53) || (idx && xo == 10'd695);
    known = (op == 6'd52) || (op == 6'd53) || (idx && (xo == 10'd663 || xo == 10'd695));
    @(negedge clk);
    instWord = w;
    instValid = 1'b1;
    fpEnable = fpOn;
    #1;
    check("R1 decodeValid", decodeValid, known);
    if (known) begin
      base = (ra == 0 && !upd) ? 64'd0 : refGpr[ra];
      sum = base + (idx ? refGpr[rb] : {{48{w[15]}}, w[15:0]});
      e.addr = sum[31:0]; e.data = fpr[fs]; e.req = req;
      e.wb = upd; e.wbIdx = 5'(ra); e.wbData = {32'd0, sum[31:0]};
      if (upd && ra == 0) e.kind = 1;
      else if (!fpOn) e.kind = 2;
      else begin
        e.kind = 0;
        if (upd) refGpr[ra] = {32'd0, sum[31:0]};
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    instValid = 1'b0;
    while (!instReady) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      gpr[i] = {32'h0, 32'h0000_1000 * i};
      fpr[i] = 32'h3F80_0000 + 32'h0101_0307 * i;
    end
    gpr[0] = 64'h0000_0000_DEAD_0000;
    gpr[4] = 64'h1234_5678_FFFF_FFF0;
    gpr[6] = 64'hFFFF_FFFF_FFFF_FF00;
    for (int i = 0; i < 32; i++) refGpr[i] = gpr[i];
    repeat (3) @(negedge clk);
    check("R8 reset", {instReady, memReqValid, pcAdvance, gprWrEn, fpUnavail, invalidForm}, 6'b100000);
    rstN = 1'b1;
    issue(encImm(0, 3, 3, 16'h0010), 1, "R2");
    issue(encImm(0, 5, 3, 16'hFFF0), 1, "R2");
    issue(encImm(0, 7, 4, 16'h0020), 1, "R2");
    issue(encImm(0, 9, 0, 16'h0044), 1, "R4");
    issue(encIdx(0, 2, 5, 6), 1, "R3");
    issue(encIdx(0, 11, 0, 7), 1, "R4");
    issue(encImm(1, 12, 7, 16'h0008), 1, "R7");
    issue(encImm(1, 13, 7, 16'hFFFC), 1, "R7");
    issue(encIdx(1, 14, 8, 9), 1, "R7");
    issue(encIdx(1, 15, 8, 9), 1, "R3");
    issue(encImm(1, 1, 0, 16'h0004), 1, "R5");
    issue(encIdx(1, 1, 0, 3), 1, "R5");
    issue(encImm(0, 1, 3, 16'h0004), 0, "R9");
    issue(encIdx(1, 1, 0, 3), 0, "R9");
    issue({6'd48, 5'd1, 5'd3, 16'h0004}, 1, "R1");
    issue({6'd31, 5'd1, 5'd3, 5'd4, 10'd664, 1'b0}, 1, "R1");
    issue(encImm(0, 20, 10, 16'h7FFF), 1, "R2");
    repeat (4) @(negedge clk);
    check("R1 no stray events", unexpected, 0);
    check("R1 queue drained", expQ.size(), 0);
    check("R7 regfile", gpr[8], refGpr[8]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule